// File: doc/BRIEF.md
# Frame-Sync Serial Transmitter

This block turns parallel words into a serial bit stream, most significant bit first, one bit per serial clock cycle. Each word is framed by a one-cycle sync pulse. The block can drive that pulse itself, or it can follow a pulse that an external master places on the sync pin. A small control input sets four things: whether every word is framed, the sync source, the sync polarity, and where the pulse sits relative to the first data bit.

Words arrive over a valid/ready handshake into a one-word holding register. The control value is captured only while the block is disabled. Once enabled, the framing scheduler starts frames, and the shifter sends each word or, if no word is waiting when a frame starts, a frame of zeros with an underflow flag.

Top module: `fstx_top`

## Requirements
- R1: While reset is high, `sd_out`, `fs_out`, `fs_oe`, `word_ready` and `underflow` are all low.
- R2: A word is sent most significant bit first, one bit per clock, `WORD_W` bits per frame.
- R3: `word_ready` is high only while the block is enabled and its holding register is empty. A word accepted on `word_valid && word_ready` is kept until its frame starts. When the block is disabled, the holding register is emptied.
- R4: When `ctrl[3]`=1, `ctrl[1]`=1 and `ctrl[0]`=1 (late, internal, framed), the sync pulse is active for exactly the cycle that carries the word's first bit. With the block enabled, a word offered in cycle k is first seen on `sd_out` in cycle k+2.
- R5: When `ctrl[3]`=0 and `ctrl[1]`=1 (early, internal), the sync pulse is active for one cycle, and the first bit follows in the next cycle.
- R6: When `ctrl[2]`=1, the sync is active low on both `fs_out` and `fs_in`. When `ctrl[2]`=0, the sync is active high. Between pulses, `fs_out` rests at the inactive level.
- R7: When `ctrl[0]`=1, every word gets its own sync pulse, and words that are waiting follow one another with no idle bit.
- R8: When `ctrl[0]`=0, only the first frame after enable carries a sync. Later frames follow back to back without a pulse.
- R9: When `ctrl[1]`=0, `fs_oe` stays low. An active `fs_in` seen at a clock edge starts the frame: the first bit appears in the next cycle in late mode, or one cycle after that in early mode.
- R10: A frame that starts with no word held sends all zeros, and `underflow` is high for the bits of that frame.
- R11: `ctrl` is captured only while `en` is low. Changes made while the block is enabled have no effect.
- R12: Once the block is disabled, `sd_out`, `fs_oe` and `word_ready` go low, and framing starts again from the first frame.
- R13: In external framed mode, an `fs_in` pulse that arrives partway through a word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable |
| ctrl | input | 4 | [0] framed, [1] internal sync, [2] active low, [3] late |
| word_data | input | WORD_W | Parallel word |
| word_valid | input | 1 | Word offered |
| word_ready | output | 1 | Word can be accepted |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Sync pin drive level |
| fs_oe | output | 1 | Sync pin drive enable |
| fs_in | input | 1 | Sync pin level from outside |
| underflow | output | 1 | Current frame had no word |

## Verification
The checker assumes that `ctrl` changes only while the block is disabled. It also assumes that a word offered with `word_valid` keeps the same data until it is accepted. The stimulus only rewrites `ctrl` with `en` low, except for the one scenario that checks that a change while enabled is ignored. It changes `word_data` only after acceptance and drives `fs_in` as single-cycle pulses at the sampling point away from the clock edge. For external sync, the checker assumes the level seen at an edge is already settled. The bench meets this by driving `fs_in` on the falling edge.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
  // bit order: [3] late, [2] act_low, [1] int_src, [0] need_sync
  typedef struct packed {
    logic late;
    logic act_low;
    logic int_src;
    logic need_sync;
  } fstx_ctrl_t;
endpackage

// File: rtl/fstx_word_hold.sv
module fstx_word_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         take,
  output logic         in_ready,
  output logic         held,
  output logic [W-1:0] held_data
);
  assign in_ready = run && !held;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      held      <= 1'b0;
      held_data <= '0;
    end else if (in_valid && in_ready) begin
      held      <= 1'b1;
      held_data <= in_data;
    end else if (take) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/fstx_frame_sched.sv
module fstx_frame_sched
  import fstx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  fstx_ctrl_t           cfg,
  input  logic                 held,
  input  logic                 fs_in,
  input  logic                 busy,
  input  logic [$clog2(W)-1:0] cnt,
  output logic                 load,
  output logic                 fs_pin,
  output logic                 fs_drv
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] PREV = CW'(W - 2);

  logic arm;
  logic stream;
  logic ext_hit;
  logic want;
  logic slot_early;
  logic slot_late;
  logic trig;
  logic pulse;

  assign ext_hit    = fs_in ^ cfg.act_low;
  assign want       = stream ? 1'b1 : (cfg.int_src ? held : ext_hit);
  assign slot_early = (!busy && !arm) || (busy && cnt == PREV);
  assign slot_late  = !busy || (cnt == LAST);
  assign trig       = run && want && (cfg.late ? slot_late : slot_early);
  assign load       = run && (cfg.late ? trig : arm);
  assign pulse      = trig && cfg.int_src && (cfg.need_sync || !stream);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm    <= 1'b0;
      stream <= 1'b0;
      fs_pin <= 1'b0;
      fs_drv <= 1'b0;
    end else if (!run) begin
      arm    <= 1'b0;
      stream <= 1'b0;
      fs_pin <= cfg.act_low;
      fs_drv <= 1'b0;
    end else begin
      arm    <= !cfg.late && trig;
      stream <= stream || (load && !cfg.need_sync);
      fs_pin <= pulse ^ cfg.act_low;
      fs_drv <= cfg.int_src;
    end
  end
endmodule

// File: rtl/fstx_bit_shifter.sv
module fstx_bit_shifter #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 load,
  input  logic                 held,
  input  logic [W-1:0]         held_data,
  output logic                 busy,
  output logic [$clog2(W)-1:0] cnt,
  output logic                 sd,
  output logic                 uf
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      busy <= 1'b0;
      cnt  <= '0;
      sr   <= '0;
      sd   <= 1'b0;
      uf   <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      sr   <= held ? held_data : '0;
      sd   <= held ? held_data[W-1] : 1'b0;
      uf   <= !held;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
        sd   <= 1'b0;
        uf   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        sd  <= sr[W-2];
        sr  <= sr << 1;
      end
    end
  end
endmodule

// File: rtl/fstx_top.sv
module fstx_top
  import fstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [3:0]        ctrl,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              sd_out,
  output logic              fs_out,
  output logic              fs_oe,
  input  logic              fs_in,
  output logic              underflow
);
  localparam int CW = $clog2(WORD_W);

  logic              en_r;
  fstx_ctrl_t        ctrl_q;
  logic              held;
  logic [WORD_W-1:0] held_data;
  logic              load;
  logic              busy;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r   <= 1'b0;
      ctrl_q <= '0;
    end else begin
      en_r <= en;
      if (!en) ctrl_q <= fstx_ctrl_t'(ctrl);
    end
  end

  fstx_word_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .run(en_r),
    .in_data(word_data), .in_valid(word_valid), .take(load),
    .in_ready(word_ready), .held(held), .held_data(held_data)
  );

  fstx_frame_sched #(.W(WORD_W)) u_sched (
    .clk(clk), .rst(rst), .run(en_r), .cfg(ctrl_q),
    .held(held), .fs_in(fs_in), .busy(busy), .cnt(cnt),
    .load(load), .fs_pin(fs_out), .fs_drv(fs_oe)
  );

  fstx_bit_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .run(en_r), .load(load),
    .held(held), .held_data(held_data),
    .busy(busy), .cnt(cnt), .sd(sd_out), .uf(underflow)
  );
endmodule

// File: rtl/fstx_chk.sv
module fstx_chk #(
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic                 int_src,
  input logic                 late,
  input logic                 act_low,
  input logic                 fs_out,
  input logic                 fs_oe,
  input logic                 sd_out,
  input logic                 underflow,
  input logic                 word_valid,
  input logic                 word_ready,
  input logic                 busy,
  input logic [$clog2(W)-1:0] cnt
);
  logic fs_act;
  assign fs_act = fs_oe && (fs_out ^ act_low);

  // R4 / R5: sync pulse lasts one cycle
  p_fs_single_r4: assert property (@(posedge clk) disable iff (rst || !run)
    fs_act |=> !(fs_out ^ act_low));

  p_late_msb_r4: assert property (@(posedge clk) disable iff (rst || !run)
    (int_src && late && fs_act) |-> (busy && cnt == '0));

  p_early_lead_r5: assert property (@(posedge clk) disable iff (rst || !run)
    (int_src && !late && fs_act) |=> (busy && cnt == '0));

  p_ext_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !int_src) |=> !fs_oe);

  p_uf_zero_r10: assert property (@(posedge clk) disable iff (rst)
    underflow |-> !sd_out);

  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> !word_ready);

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sd_out && !fs_oe && !underflow));
endmodule

bind fstx_top fstx_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .run(en_r),
  .int_src(ctrl_q.int_src), .late(ctrl_q.late), .act_low(ctrl_q.act_low),
  .fs_out(fs_out), .fs_oe(fs_oe), .sd_out(sd_out), .underflow(underflow),
  .word_valid(word_valid), .word_ready(word_ready),
  .busy(busy), .cnt(cnt)
);

// File: tb/fstx_top_test.sv
`timescale 1ns/1ps
module fstx_top_test;
  localparam int W = 16;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [3:0]   ctrl = 4'b0;
  logic [W-1:0] word_data = '0;
  logic         word_valid = 1'b0;
  logic         word_ready;
  logic         sd_out;
  logic         fs_out;
  logic         fs_oe;
  logic         fs_in = 1'b0;
  logic         underflow;

  int checks = 0;
  int errors = 0;

  logic sd_log [N];
  logic fs_log [N];
  logic fr_log [N];
  logic oe_log [N];
  logic uf_log [N];

  always #2.5 clk = ~clk;

  fstx_top #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .ctrl(ctrl),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .sd_out(sd_out), .fs_out(fs_out), .fs_oe(fs_oe), .fs_in(fs_in),
    .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] c);
    @(negedge clk);
    en    = 1'b0;
    ctrl  = c;
    fs_in = c[2];
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = d;
    forever begin
      if (word_ready) begin
        @(negedge clk);
        word_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic capture(input int p1, input int p2, input int p3, input logic pol);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      sd_log[k] = sd_out;
      fr_log[k] = fs_out;
      oe_log[k] = fs_oe;
      fs_log[k] = fs_oe && (fs_out != pol);
      uf_log[k] = underflow;
      fs_in = (k == p1 || k == p2 || k == p3) ? !pol : pol;
    end
    fs_in = pol;
  endtask

  function automatic int first_fs();
    for (int k = 0; k < N; k++) if (fs_log[k]) return k;
    return -1;
  endfunction

  function automatic int fs_count();
    int n = 0;
    for (int k = 0; k < N; k++) if (fs_log[k]) n++;
    return n;
  endfunction

  function automatic logic [W-1:0] word_at(input int s);
    logic [W-1:0] v = '0;
    for (int i = 0; i < W; i++) v = {v[W-2:0], (s + i >= 0 && s + i < N) ? sd_log[s + i] : 1'bx};
    return v;
  endfunction

  function automatic bit uf_span(input int s, input logic lvl);
    for (int i = 0; i < W; i++) if (s + i < 0 || s + i >= N || uf_log[s + i] != lvl) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(sd_out == 0 && fs_out == 0 && fs_oe == 0, "R1 reset pins", {sd_out, fs_out, fs_oe}, 0);
    chk(word_ready == 0 && underflow == 0, "R1 reset ready/uf", {word_ready, underflow}, 0);
    rst = 1'b0;
  endtask

  task automatic t_int_late();
    int f;
    setup(4'b1011);
    fork
      begin push(16'hA5C3); push(16'h3C0F); end
      capture(-1, -1, -1, 1'b0);
    join
    f = first_fs();
    chk(f == 2, "R4 late sync latency", f, 2);
    chk(word_at(f) == 16'hA5C3, "R2 R4 first word MSB first under sync", word_at(f), 16'hA5C3);
    chk(fs_log[f + 16] == 1, "R7 second word has own sync", fs_log[f + 16], 1);
    chk(word_at(f + 16) == 16'h3C0F, "R7 back to back second word", word_at(f + 16), 16'h3C0F);
    chk(fs_count() == 2, "R4 one cycle pulses", fs_count(), 2);
    chk(sd_log[f + 33] == 0 && uf_log[f + 33] == 0, "R2 idle after words", sd_log[f + 33], 0);
    chk(word_ready == 1, "R3 ready when empty", word_ready, 1);
  endtask

  task automatic t_int_early_low();
    int f;
    setup(4'b0111);
    fork
      begin push(16'h8001); push(16'h7FFE); end
      capture(-1, -1, -1, 1'b1);
    join
    f = first_fs();
    chk(f == 2, "R5 early sync cycle", f, 2);
    chk(word_at(f + 1) == 16'h8001, "R5 word follows sync", word_at(f + 1), 16'h8001);
    chk(fr_log[f] == 0 && fr_log[f + 1] == 1 && fr_log[0] == 1, "R6 active low pulse",
        {fr_log[0], fr_log[f], fr_log[f + 1]}, 3'b101);
    chk(fs_log[f + 16] == 1 && word_at(f + 17) == 16'h7FFE, "R5 R7 early sync before second word",
        word_at(f + 17), 16'h7FFE);
  endtask

  task automatic t_int_cont();
    int f;
    setup(4'b1010);
    fork
      begin push(16'hF00D); push(16'h1234); end
      capture(-1, -1, -1, 1'b0);
    join
    f = first_fs();
    chk(f == 2 && word_at(f) == 16'hF00D, "R8 first framed word", word_at(f), 16'hF00D);
    chk(word_at(f + 16) == 16'h1234 && fs_count() == 1, "R8 next word without sync",
        fs_count(), 1);
    chk(uf_span(f, 1'b0) && uf_span(f + 16, 1'b0), "R10 no underflow with data", uf_log[f], 0);
    chk(word_at(f + 32) == 0 && uf_span(f + 32, 1'b1), "R10 continuous underflow frame",
        uf_log[f + 32], 1);
  endtask

  task automatic t_ext_late();
    setup(4'b1001);
    push(16'hC0DE);
    capture(2, 7, 25, 1'b0);
    chk(fs_count() == 0 && oe_log[10] == 0, "R9 external no drive", oe_log[10], 0);
    chk(word_at(3) == 16'hC0DE, "R9 late external start", word_at(3), 16'hC0DE);
    chk(uf_span(3, 1'b0) && sd_log[20] == 0, "R13 mid-word sync ignored", uf_log[8], 0);
    chk(word_at(26) == 0 && uf_span(26, 1'b1), "R10 external empty frame", uf_log[26], 1);
  endtask

  task automatic t_ext_early_low_cont();
    setup(4'b0100);
    push(16'h5AA5);
    fork
      push(16'h0FF0);
      capture(2, -1, -1, 1'b1);
    join
    chk(word_at(4) == 16'h5AA5, "R9 R6 early external active low", word_at(4), 16'h5AA5);
    chk(word_at(20) == 16'h0FF0, "R8 external continuous", word_at(20), 16'h0FF0);
    chk(uf_span(36, 1'b1), "R10 continuous external underflow", uf_log[36], 1);
  endtask

  task automatic t_ctrl_lock();
    int f;
    setup(4'b1011);
    ctrl = 4'b0000;
    fork
      push(16'h9C63);
      capture(-1, -1, -1, 1'b0);
    join
    f = first_fs();
    chk(f == 2 && word_at(f) == 16'h9C63, "R11 ctrl change ignored while enabled", f, 2);
    fork
      push(16'hFFFF);
      begin repeat (4) @(negedge clk); en = 1'b0; end
    join
    repeat (3) @(negedge clk);
    chk(sd_out == 0 && fs_oe == 0 && word_ready == 0, "R12 disable quiets", {sd_out, fs_oe, word_ready}, 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(fs_oe == 0, "R11 new ctrl taken after disable", fs_oe, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_int_late();
    t_int_early_low();
    t_int_cont();
    t_ext_late();
    t_ext_early_low_cont();
    t_ctrl_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule